// File: doc/BRIEF.md
# Random-Access Reusable Channel Buffer

This block sits on the channel between a producing node and a consuming node in a streaming pipeline. A strict FIFO there would force reads in write order and remove each value as it is read. Here, the producer streams samples in over a valid/ready input, and the block copies them in order into local storage. The storage is split into two banks of N = 2^BLK_LOG2 samples each. The producer fills one bank while the consumer works on the other.

The consumer sends read requests on a second valid/ready stream. Each request carries a sample index. It gets the stored sample back on a valid/ready response stream one cycle later. Reads do not remove data: any index may be read any number of times, in any order, and some samples may never be read at all. A per-block mode chooses how the index is interpreted: as a plain linear position, or as a bit-reversed position, which suits decimation-in-time FFT stages. When the consumer has finished with a block, it pulses a release pin. The bank goes back to the producer, any values not read are dropped, and reads move on to the next completed block.

Back-pressure rules are as follows. `in_ready` is low while both banks hold completed blocks. `rq_ready` is low while no completed block is waiting, and also while a response is held back by `rs_ready` low. A response stays valid and unchanged until it is accepted.

Top module: `reuse_chan_buf`

## Requirements
- R1: After reset, `in_ready` is 1, `rq_ready` is 0 and `rs_valid` is 0.
- R2: Accepted input samples fill a block in order. The block becomes readable after its N-th accepted sample, and `in_ready` stays high while a bank is free.
- R3: After two completed blocks with no release, `in_ready` is 0. Data offered then is not stored and does not disturb either stored block.
- R4: `rq_ready` is 0 whenever no completed block is waiting, and no response is produced then.
- R5: In linear mode (`rev_mode` = 0), index k returns the k-th sample of the current block, counting from 0.
- R6: In bit-reversed mode (`rev_mode` = 1), index k returns the sample whose position is k with its BLK_LOG2 bits in reverse order.
- R7: Reading does not consume data: repeated reads of the same index return the same value.
- R8: The mode is taken from `rev_mode` on the first accepted request of a block. It holds for the rest of that block, whatever `rev_mode` does, until a release.
- R9: A `release_blk` pulse while a block is readable frees that bank. `in_ready` is 1 in the next cycle, and reads then come from the next completed block.
- R10: A `release_blk` pulse while no block is readable has no effect.
- R11: `rs_valid` rises in the cycle after an accepted request. While `rs_valid` is 1 and `rs_ready` is 0, `rs_data` is stable and `rq_ready` is 0.
- R12: Blocks reach the consumer in the order they were written. Releasing a block that was read sparsely or not at all drops its unread samples and does not shift later blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DATA_W | Producer sample |
| rq_valid | input | 1 | Consumer read request valid |
| rq_ready | output | 1 | Read request can be accepted |
| rq_index | input | BLK_LOG2 | Sample index within the current block |
| rev_mode | input | 1 | Index mode for the block: 0 linear, 1 bit-reversed |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Consumer accepts the response |
| rs_data | output | DATA_W | Read response sample |
| release_blk | input | 1 | Pulse: consumer is done with the current block |

## Verification
A wrong bank flag or bank pointer shows up at the ports in the same cycle. It appears as `in_ready` or `rq_ready` at the wrong level, or, a cycle after a release, as data from the wrong block. A wrong write pointer or index mapping shows up one cycle after the faulty request, as a wrong `rs_data` value. The bench gives every sample a distinct arithmetic value, so a single misplaced address is caught by the first read that touches it. It sweeps every index in both modes over many blocks, so a mapping fault is found within a block.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;
  typedef enum logic {
    IDX_LINEAR = 1'b0,
    IDX_BITREV = 1'b1
  } idx_mode_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/chbuf_wr_side.sv
module chbuf_wr_side #(
  parameter int BLK_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  output logic                wr_bank,
  output logic [BLK_LOG2-1:0] wr_ptr,
  output logic                wr_last
);
  localparam logic [BLK_LOG2-1:0] PTR_MAX = '1;

  logic                bank_q;
  logic [BLK_LOG2-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      ptr_q  <= '0;
    end else if (wr_fire) begin
      if (ptr_q == PTR_MAX) begin
        ptr_q  <= '0;
        bank_q <= ~bank_q;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign wr_bank = bank_q;
  assign wr_ptr  = ptr_q;
  assign wr_last = (ptr_q == PTR_MAX);

  // R2: the last sample of a block moves filling to the other bank at slot 0
  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_last) |=> (ptr_q == '0 && bank_q != $past(bank_q)));
endmodule

// File: rtl/chbuf_bank_state.sv
module chbuf_bank_state
  import chbuf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_done,
  input  logic                 fill_bank,
  input  logic                 rel_req,
  output logic [NUM_BANKS-1:0] full,
  output logic                 rd_bank,
  output logic                 rd_avail,
  output logic                 rel_eff
);
  logic [NUM_BANKS-1:0] full_q;
  logic                 rd_bank_q;

  assign rd_avail = full_q[rd_bank_q];
  assign rel_eff  = rel_req && rd_avail;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic BID = 1'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q[g] <= 1'b0;
      end else if (fill_done && fill_bank == BID) begin
        full_q[g] <= 1'b1;
      end else if (rel_eff && rd_bank_q == BID) begin
        full_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_bank_q <= 1'b0;
    end else if (rel_eff) begin
      rd_bank_q <= ~rd_bank_q;
    end
  end

  assign full    = full_q;
  assign rd_bank = rd_bank_q;

  // R2: a completed block is marked readable in the next cycle
  assert_fill_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> full_q[$past(fill_bank)]);

  // R9: an honoured release moves the consumer to the other bank
  assert_release_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_eff |=> (rd_bank_q != $past(rd_bank_q)));

  // R10: a release with nothing readable leaves the bank state alone
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !rd_avail && !fill_done) |=> ($stable(full_q) && $stable(rd_bank_q)));
endmodule

// File: rtl/chbuf_addr_map.sv
module chbuf_addr_map #(
  parameter int BLK_LOG2 = 3
) (
  input  logic [BLK_LOG2-1:0] index,
  input  logic                bitrev,
  output logic [BLK_LOG2-1:0] slot
);
  logic [BLK_LOG2-1:0] swapped;

  for (genvar i = 0; i < BLK_LOG2; i++) begin : g_swap
    assign swapped[i] = index[BLK_LOG2-1-i];
  end

  assign slot = bitrev ? swapped : index;
endmodule

// File: rtl/chbuf_mem.sv
module chbuf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    if (re) begin
      rdata_q <= store[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/reuse_chan_buf.sv
module reuse_chan_buf
  import chbuf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BLK_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                rq_valid,
  output logic                rq_ready,
  input  logic [BLK_LOG2-1:0] rq_index,
  input  logic                rev_mode,
  output logic                rs_valid,
  input  logic                rs_ready,
  output logic [DATA_W-1:0]   rs_data,
  input  logic                release_blk
);
  localparam int ADDR_W = BLK_LOG2 + 1;

  logic                 wr_fire, wr_bank, wr_last;
  logic [BLK_LOG2-1:0]  wr_ptr;
  logic [NUM_BANKS-1:0] full;
  logic                 rd_bank, rd_avail, rel_eff;
  logic                 rd_fire;
  logic                 rs_valid_q;
  logic                 started_q;
  idx_mode_e            mode_q, mode_eff;
  logic [BLK_LOG2-1:0]  rd_slot;

  assign in_ready = !full[wr_bank];
  assign wr_fire  = in_valid && in_ready;
  assign rq_ready = rd_avail && (!rs_valid_q || rs_ready);
  assign rd_fire  = rq_valid && rq_ready;

  chbuf_wr_side #(.BLK_LOG2(BLK_LOG2)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_bank (wr_bank),
    .wr_ptr  (wr_ptr),
    .wr_last (wr_last)
  );

  chbuf_bank_state u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_done (wr_fire && wr_last),
    .fill_bank (wr_bank),
    .rel_req   (release_blk),
    .full      (full),
    .rd_bank   (rd_bank),
    .rd_avail  (rd_avail),
    .rel_eff   (rel_eff)
  );

  // Mode is fixed by the first request of a block.
  assign mode_eff = started_q ? mode_q : idx_mode_e'(rev_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      mode_q    <= IDX_LINEAR;
    end else if (rel_eff) begin
      started_q <= 1'b0;
    end else if (rd_fire) begin
      started_q <= 1'b1;
      mode_q    <= mode_eff;
    end
  end

  chbuf_addr_map #(.BLK_LOG2(BLK_LOG2)) u_map (
    .index  (rq_index),
    .bitrev (mode_eff == IDX_BITREV),
    .slot   (rd_slot)
  );

  chbuf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (wr_fire),
    .waddr ({wr_bank, wr_ptr}),
    .wdata (in_data),
    .re    (rd_fire),
    .raddr ({rd_bank, rd_slot}),
    .rdata (rs_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
    end else if (rd_fire) begin
      rs_valid_q <= 1'b1;
    end else if (rs_ready) begin
      rs_valid_q <= 1'b0;
    end
  end

  assign rs_valid = rs_valid_q;

  // R3: the producer never writes into the bank being read
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_avail) |-> (wr_bank != rd_bank));

  // R11: an accepted request yields a response next cycle
  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rs_valid);

  // R11: a stalled response holds its value
  assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));

  // R8: once a block has started, the latched mode does not move before release
  assert_mode_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !rel_eff) |=> (started_q && $stable(mode_q)));
endmodule

// File: tb/sim_reuse_chan_buf.sv
module sim_reuse_chan_buf;
  localparam int DW = 8;
  localparam int LG = 3;
  localparam int N  = 1 << LG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic rq_valid = 1'b0, rq_ready;
  logic [LG-1:0] rq_index = '0;
  logic rev_mode = 1'b0;
  logic rs_valid, rs_ready = 1'b1;
  logic [DW-1:0] rs_data;
  logic release_blk = 1'b0;

  int checks = 0;
  int errors = 0;
  int wr_blk = 0;
  int rd_blk = 0;
  bit finished = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  reuse_chan_buf #(.DATA_W(DW), .BLK_LOG2(LG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_index(rq_index),
    .rev_mode(rev_mode),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .release_blk(release_blk)
  );

  function automatic int sample_of(int blk, int pos);
    return (((blk * N + pos) * 37) + 5) % 256;
  endfunction

  function automatic int brev(int k);
    int r = 0;
    for (int i = 0; i < LG; i++) r = r | (((k >> i) & 1) << (LG - 1 - i));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      summary();
    end
  end

  task automatic push_block();
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1;
      in_data  = DW'(sample_of(wr_blk, i));
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wr_blk++;
  endtask

  task automatic read_one(input int idx, input bit rev, output int data, output bit got);
    int waitc = 0;
    rq_valid = 1'b1;
    rq_index = LG'(idx);
    rev_mode = rev;
    got = 0;
    data = -1;
    while (!rq_ready && waitc < 20) begin
      @(negedge clk);
      waitc++;
    end
    if (rq_ready) begin
      @(negedge clk);
      got = 1;
      data = int'(rs_data);
    end
    rq_valid = 1'b0;
  endtask

  task automatic release_now();
    release_blk = 1'b1;
    @(negedge clk);
    release_blk = 1'b0;
  endtask

  task automatic sweep_block(input bit rev, input string req);
    int d;
    bit g;
    for (int k = 0; k < N; k++) begin
      int pos = rev ? brev(k) : k;
      read_one(k, rev, d, g);
      check(g && d == sample_of(rd_blk, pos), req, d, sample_of(rd_blk, pos));
    end
  endtask

  initial begin
    int d;
    bit g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    check(rq_ready == 1'b0, "R1", int'(rq_ready), 0);
    check(rs_valid == 1'b0, "R1", int'(rs_valid), 0);

    // R4: requests with no completed block are refused
    rq_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rq_ready == 1'b0 && rs_valid == 1'b0, "R4", int'(rq_ready), 0);
    end
    rq_valid = 1'b0;

    // R10: release with nothing readable is ignored
    release_now();

    // R2: first block, in_ready stays high while a bank is free
    push_block();
    check(in_ready == 1'b1, "R2", int'(in_ready), 1);
    check(rq_ready == 1'b1, "R2", int'(rq_ready), 1);

    // R5 and R10: linear sweep returns block 0
    sweep_block(1'b0, "R5");

    // R7: repeated reads of one index
    for (int r = 0; r < 5; r++) begin
      read_one(3, 1'b0, d, g);
      check(g && d == sample_of(0, 3), "R7", d, sample_of(0, 3));
    end

    // R3: fill the second bank, then the producer must stall
    push_block();
    check(in_ready == 1'b0, "R3", int'(in_ready), 0);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R3", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    read_one(0, 1'b0, d, g);
    check(g && d == sample_of(0, 0), "R3", d, sample_of(0, 0));

    // R9: release frees a bank for the producer
    release_now();
    rd_blk = 1;
    check(in_ready == 1'b1, "R9", int'(in_ready), 1);

    // R6 and R8: first request bit-reversed, later ones claim linear
    for (int k = 0; k < N; k++) begin
      read_one(k, (k == 0), d, g);
      check(g && d == sample_of(1, brev(k)), "R8", d, sample_of(1, brev(k)));
    end
    // R6: rereading block 1 in the latched mode
    sweep_block(1'b1, "R6");

    // R12: block 2 is read sparsely, then released
    push_block();
    release_now();
    rd_blk = 2;
    read_one(1, 1'b0, d, g);
    check(g && d == sample_of(2, 1), "R12", d, sample_of(2, 1));
    read_one(6, 1'b0, d, g);
    check(g && d == sample_of(2, 6), "R12", d, sample_of(2, 6));
    release_now();
    rd_blk = 3;
    check(rq_ready == 1'b0, "R4", int'(rq_ready), 0);

    // R11: held response
    push_block();
    rs_ready = 1'b0;
    read_one(5, 1'b0, d, g);
    check(g && rs_valid && d == sample_of(3, 5), "R11", d, sample_of(3, 5));
    rq_valid = 1'b1;
    rq_index = 3'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rs_valid && rq_ready == 1'b0, "R11", int'(rq_ready), 0);
      check(int'(rs_data) == sample_of(3, 5), "R11", int'(rs_data), sample_of(3, 5));
    end
    rq_valid = 1'b0;
    rs_ready = 1'b1;
    @(negedge clk);
    check(rs_valid == 1'b0, "R11", int'(rs_valid), 0);
    release_now();
    rd_blk = 4;

    // Sweep: many blocks, both modes, with ping-pong overlap
    push_block();
    for (int b = 0; b < 8; b++) begin
      push_block();
      sweep_block(b[0], b[0] ? "R6" : "R5");
      release_now();
      rd_blk++;
    end
    sweep_block(1'b0, "R12");
    release_now();
    rd_blk++;
    check(rq_ready == 1'b0, "R4", int'(rq_ready), 0);
    check(in_ready == 1'b1, "R9", int'(in_ready), 1);

    summary();
  end
endmodule